// File: doc/BRIEF.md
# Longest-Prefix Lookup by Range-Endpoint Search

This block resolves the longest matching prefix of an address by searching a sorted table of full-width range endpoints. Every prefix is turned offline into two keys: its low end (the prefix followed by zeros) and its high end (the prefix followed by ones). All keys sit in ascending order in one synchronous table. Each entry also carries two precomputed next-hop codes. The equal code applies when the address hits the key exactly. The greater code applies when the address lies between this key and the next one. Because both codes are stored, a search that stops between two keys resolves at once to the enclosing prefix, with no walk back through the table.

A lookup starts when `req_valid_i` is seen while the engine is idle. The engine then reads the table once per cycle on a fixed schedule. It settles on the largest key that is less than or equal to the address and picks the equal or greater code of that entry. It returns the code with a one-cycle strobe. Only one lookup runs at a time. The table is loaded through a plain write port. Unused tail entries are filled by the loader with the all-ones key, so the probe schedule never depends on how many prefixes are present.

Top module: `lpm_range_search`

## Requirements
- R1: After reset `busy_o` and `rsp_valid_o` are low and `rsp_code_o` is zero.
- R2: A cycle with `wr_en_i` high stores `wr_key_i`, `wr_eq_i` and `wr_gt_i` at entry `wr_idx_i`; later lookups use the new contents.
- R3: When the address equals the largest key not above it, the response is that entry's equal code.
- R4: When the address is strictly greater than the largest key not above it, the response is that entry's greater code.
- R5: When the address is below entry 0's key, the response is the `NO_ROUTE` parameter value.
- R6: The last entry (index 2^DEPTH_LOG2-1) is selectable: an address at or above its key resolves through it.
- R7: `rsp_valid_o` is high for exactly one cycle, at the (DEPTH_LOG2+2)th rising edge after the edge that accepted the request, whatever the address. Each lookup makes exactly DEPTH_LOG2+1 table reads.
- R8: `busy_o` is high from the edge that accepts a request until the edge that raises `rsp_valid_o`. Requests that arrive while `busy_o` is high are ignored: they cause no extra response and do not change the code of the lookup in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request, accepted when idle |
| req_addr_i | input | KEY_W | Address to resolve |
| busy_o | output | 1 | Lookup in progress |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| rsp_code_o | output | RES_W | Next-hop code, held until the next result |
| wr_en_i | input | 1 | Table write enable |
| wr_idx_i | input | DEPTH_LOG2 | Entry index to write |
| wr_key_i | input | KEY_W | Endpoint key |
| wr_eq_i | input | RES_W | Code used on exact key match |
| wr_gt_i | input | RES_W | Code used when the address exceeds the key |

## Verification
A wrong probe base or a missed candidate capture shows as a wrong code, but only for addresses near certain keys. For that reason every address of a small 8-bit configuration is swept against prefix sets that are nested, disjoint, full-table and host-only, and each result is compared with a longest-prefix match computed directly from the prefix list. A stale step counter or state shows at the ports within a single lookup, as a strobe at the wrong edge or as `busy_o` overlapping the strobe. A request taken while busy would show as a second strobe in the cycles after the first one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lpm_state_e;
endpackage

// File: rtl/lpm_table_mem.sv
module lpm_table_mem #(
  parameter int KEY_W      = 16,
  parameter int RES_W      = 16,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic                  clk_i,
  input  logic                  wr_en_i,
  input  logic [DEPTH_LOG2-1:0] wr_idx_i,
  input  logic [KEY_W-1:0]      wr_key_i,
  input  logic [RES_W-1:0]      wr_eq_i,
  input  logic [RES_W-1:0]      wr_gt_i,
  input  logic                  rd_en_i,
  input  logic [DEPTH_LOG2-1:0] rd_idx_i,
  output logic [KEY_W-1:0]      rd_key_o,
  output logic [RES_W-1:0]      rd_eq_o,
  output logic [RES_W-1:0]      rd_gt_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int ENT_W = KEY_W + 2 * RES_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= {wr_key_i, wr_eq_i, wr_gt_i};
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_q <= mem_q[rd_idx_i];
  end

  assign rd_key_o = rd_q[ENT_W-1 -: KEY_W];
  assign rd_eq_o  = rd_q[2*RES_W-1 -: RES_W];
  assign rd_gt_o  = rd_q[RES_W-1:0];
endmodule

// File: rtl/lpm_probe_ctrl.sv
module lpm_probe_ctrl
  import lpm_pkg::*;
#(
  parameter int KEY_W      = 16,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [KEY_W-1:0]      req_addr_i,
  input  logic                  taken_i,
  output logic                  busy_o,
  output logic                  start_o,
  output logic                  rd_en_o,
  output logic [DEPTH_LOG2-1:0] rd_idx_o,
  output logic [KEY_W-1:0]      addr_o,
  output logic                  eval_o,
  output logic                  first_o,
  output logic                  last_o
);
  localparam int LAST_STEP = DEPTH_LOG2 + 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST_STEP);

  lpm_state_e            state_q;
  logic [STEP_W-1:0]     step_q;
  logic [DEPTH_LOG2-1:0] base_q, base_upd;
  logic [KEY_W-1:0]      addr_q;
  logic                  run;

  assign run     = (state_q == ST_RUN);
  assign busy_o  = run;
  assign start_o = !run && req_valid_i;
  assign eval_o  = run && (step_q != '0);
  assign first_o = run && (step_q == STEP_W'(1));
  assign last_o  = run && (step_q == LAST_S);
  assign rd_en_o = run && (step_q != LAST_S);
  assign addr_o  = addr_q;

  // evaluating probe step_q-1 (>=1) moves the base by 2^(L+1-step_q)
  always_comb begin
    base_upd = base_q;
    if (eval_o && !first_o && taken_i)
      base_upd = base_q + (DEPTH_LOG2'(1) << (LAST_S - step_q));
  end

  // step 0 probes the top entry, step k probes base + 2^(L-k) - 1
  always_comb begin
    if (step_q == '0) rd_idx_o = '1;
    else rd_idx_o = base_upd + (DEPTH_LOG2'(1) << (LAST_S - STEP_W'(1) - step_q))
                    - DEPTH_LOG2'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
    end else if (!run) begin
      if (req_valid_i) begin
        state_q <= ST_RUN;
        step_q  <= '0;
        base_q  <= '0;
        addr_q  <= req_addr_i;
      end
    end else begin
      step_q <= step_q + STEP_W'(1);
      base_q <= base_upd;
      if (step_q == LAST_S) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/lpm_match_unit.sv
module lpm_match_unit #(
  parameter int               KEY_W    = 16,
  parameter int               RES_W    = 16,
  parameter logic [RES_W-1:0] NO_ROUTE = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             eval_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [KEY_W-1:0] addr_i,
  input  logic [KEY_W-1:0] rd_key_i,
  input  logic [RES_W-1:0] rd_eq_i,
  input  logic [RES_W-1:0] rd_gt_i,
  output logic             taken_o,
  output logic             rsp_valid_o,
  output logic [RES_W-1:0] rsp_code_o
);
  logic             done_q, hit_q;
  logic [KEY_W-1:0] key_q;
  logic [RES_W-1:0] eq_q, gt_q;
  logic             f_hit;
  logic [KEY_W-1:0] f_key;
  logic [RES_W-1:0] f_eq, f_gt, f_code;
  logic             rsp_valid_q;
  logic [RES_W-1:0] rsp_code_q;

  // once the top entry matched, later probes cannot improve on it
  assign taken_o = eval_i && !done_q && (rd_key_i <= addr_i);

  assign f_hit  = taken_o | hit_q;
  assign f_key  = taken_o ? rd_key_i : key_q;
  assign f_eq   = taken_o ? rd_eq_i  : eq_q;
  assign f_gt   = taken_o ? rd_gt_i  : gt_q;
  assign f_code = !f_hit ? NO_ROUTE : ((addr_i == f_key) ? f_eq : f_gt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      key_q  <= '0;
      eq_q   <= '0;
      gt_q   <= '0;
    end else if (start_i) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (taken_o) begin
      done_q <= first_i;
      hit_q  <= 1'b1;
      key_q  <= rd_key_i;
      eq_q   <= rd_eq_i;
      gt_q   <= rd_gt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= '0;
    end else begin
      rsp_valid_q <= last_i;
      if (last_i) rsp_code_q <= f_code;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
endmodule

// File: rtl/lpm_range_search.sv
module lpm_range_search #(
  parameter int               KEY_W      = 16,
  parameter int               RES_W      = 16,
  parameter int               DEPTH_LOG2 = 6,
  parameter logic [RES_W-1:0] NO_ROUTE   = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [KEY_W-1:0]      req_addr_i,
  output logic                  busy_o,
  output logic                  rsp_valid_o,
  output logic [RES_W-1:0]      rsp_code_o,
  input  logic                  wr_en_i,
  input  logic [DEPTH_LOG2-1:0] wr_idx_i,
  input  logic [KEY_W-1:0]      wr_key_i,
  input  logic [RES_W-1:0]      wr_eq_i,
  input  logic [RES_W-1:0]      wr_gt_i
);
  logic                  probe_rd_en;
  logic [DEPTH_LOG2-1:0] probe_idx;
  logic [KEY_W-1:0]      rd_key, cur_addr;
  logic [RES_W-1:0]      rd_eq, rd_gt;
  logic                  start, eval, first, last, taken;

  lpm_table_mem #(
    .KEY_W(KEY_W), .RES_W(RES_W), .DEPTH_LOG2(DEPTH_LOG2)
  ) i_table (
    .clk_i   (clk_i),
    .wr_en_i (wr_en_i),
    .wr_idx_i(wr_idx_i),
    .wr_key_i(wr_key_i),
    .wr_eq_i (wr_eq_i),
    .wr_gt_i (wr_gt_i),
    .rd_en_i (probe_rd_en),
    .rd_idx_i(probe_idx),
    .rd_key_o(rd_key),
    .rd_eq_o (rd_eq),
    .rd_gt_o (rd_gt)
  );

  lpm_probe_ctrl #(
    .KEY_W(KEY_W), .DEPTH_LOG2(DEPTH_LOG2)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_addr_i (req_addr_i),
    .taken_i    (taken),
    .busy_o     (busy_o),
    .start_o    (start),
    .rd_en_o    (probe_rd_en),
    .rd_idx_o   (probe_idx),
    .addr_o     (cur_addr),
    .eval_o     (eval),
    .first_o    (first),
    .last_o     (last)
  );

  lpm_match_unit #(
    .KEY_W(KEY_W), .RES_W(RES_W), .NO_ROUTE(NO_ROUTE)
  ) i_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .eval_i     (eval),
    .first_i    (first),
    .last_i     (last),
    .addr_i     (cur_addr),
    .rd_key_i   (rd_key),
    .rd_eq_i    (rd_eq),
    .rd_gt_i    (rd_gt),
    .taken_o    (taken),
    .rsp_valid_o(rsp_valid_o),
    .rsp_code_o (rsp_code_o)
  );
endmodule

// File: rtl/lpm_range_search_chk.sv
module lpm_range_search_chk #(
  parameter int DEPTH_LOG2 = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic rsp_valid_o,
  input logic rd_en_i
);
  localparam logic [7:0] LAT   = 8'(DEPTH_LOG2 + 3);
  localparam logic [7:0] READS = 8'(DEPTH_LOG2 + 1);

  logic [7:0] lat_q, rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      rd_cnt_q <= '0;
    end else if (req_valid_i && !busy_o) begin
      lat_q    <= 8'd1;
      rd_cnt_q <= '0;
    end else begin
      if (busy_o) lat_q <= lat_q + 8'd1;
      if (rd_en_i) rd_cnt_q <= rd_cnt_q + 8'd1;
    end
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);
  // R8
  busy_strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && rsp_valid_o));
  // R7
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R7
  strobe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> lat_q == LAT);
  // R7
  probe_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rd_cnt_q == READS);
endmodule

bind lpm_range_search lpm_range_search_chk #(.DEPTH_LOG2(DEPTH_LOG2)) i_lpm_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .rsp_valid_o(rsp_valid_o),
  .rd_en_i    (probe_rd_en)
);

// File: tb/test_lpm_range_search.sv
module test_lpm_range_search;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;
  localparam int RW = 8;
  localparam int DL = 4;
  localparam int DEPTH = 1 << DL;
  localparam logic [RW-1:0] NO_RT = 8'hFF;
  localparam int EXP_EDGES = DL + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [KW-1:0] req_addr = '0;
  logic busy, rsp_valid;
  logic [RW-1:0] rsp_code;
  logic wr_en = 1'b0;
  logic [DL-1:0] wr_idx = '0;
  logic [KW-1:0] wr_key = '0;
  logic [RW-1:0] wr_eq = '0, wr_gt = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int pv[8];
  int pl[8];
  int np;
  int ek[32];
  int nk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpm_range_search #(
    .KEY_W(KW), .RES_W(RW), .DEPTH_LOG2(DL), .NO_ROUTE(NO_RT)
  ) i_lpm_range_search (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_key_i(wr_key),
    .wr_eq_i(wr_eq), .wr_gt_i(wr_gt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_lpm(input int a);
    int best_len = -1;
    int code = NO_RT;
    for (int i = 0; i < np; i++) begin
      if ((pl[i] == 0 || (a >> (KW - pl[i])) == pv[i]) && pl[i] > best_len) begin
        best_len = pl[i];
        code = i + 1;
      end
    end
    return code;
  endfunction

  task automatic add_key(input int k);
    for (int i = 0; i < nk; i++) if (ek[i] == k) return;
    ek[nk] = k;
    nk++;
  endtask

  task automatic write_entry(input int idx, input int key, input int eq, input int gt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = DL'(idx); wr_key = KW'(key); wr_eq = RW'(eq); wr_gt = RW'(gt);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic build_table();
    int t;
    nk = 0;
    for (int i = 0; i < np; i++) begin
      int lo = (pv[i] << (KW - pl[i])) & 255;
      int hi = lo | ((1 << (KW - pl[i])) - 1);
      add_key(lo);
      add_key(hi);
    end
    for (int i = 0; i < nk; i++)
      for (int j = 0; j + 1 < nk - i; j++)
        if (ek[j] > ek[j+1]) begin t = ek[j]; ek[j] = ek[j+1]; ek[j+1] = t; end
    for (int i = 0; i < DEPTH; i++) begin
      int key = (i < nk) ? ek[i] : 255;
      write_entry(i, key, ref_lpm(key), ref_lpm(key < 255 ? key + 1 : 255));
    end
  endtask

  task automatic lookup(input int a, output int code, output int edges, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_addr = KW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    edges = 1;
    busy_ok = 1'b1;
    while (!rsp_valid && edges < 40) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      edges++;
    end
    if (busy) busy_ok = 1'b0;
    code = rsp_code;
    @(negedge clk);
    if (rsp_valid) edges = -1;
  endtask

  task automatic sweep(input string set_name);
    int code, edges, tmax;
    bit bok;
    tmax = (nk < DEPTH) ? 255 : ek[DEPTH-1];
    for (int a = 0; a < 256; a++) begin
      string tag;
      bit is_key = 1'b0;
      for (int i = 0; i < nk; i++) if (ek[i] == a) is_key = 1'b1;
      if (a < ek[0]) tag = "R5 below first key";
      else if (a >= tmax) tag = "R6 last entry";
      else if (is_key) tag = "R3 equal match";
      else tag = "R4 greater match";
      lookup(a, code, edges, bok);
      chk(code == ref_lpm(a), {tag, " ", set_name}, code, ref_lpm(a));
      chk(edges == EXP_EDGES, {"R7 strobe timing ", set_name}, edges, EXP_EDGES);
      chk(bok, {"R8 busy window ", set_name}, int'(bok), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int code, edges, seen;
    bit bok;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!rsp_valid, "R1 strobe after reset", int'(rsp_valid), 0);
    chk(rsp_code == 0, "R1 code after reset", int'(rsp_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // set A: nested ranges plus a host route at the top
    np = 6;
    pv[0] = 1;   pl[0] = 1;
    pv[1] = 5;   pl[1] = 3;
    pv[2] = 21;  pl[2] = 5;
    pv[3] = 0;   pl[3] = 2;
    pv[4] = 6;   pl[4] = 4;
    pv[5] = 255; pl[5] = 8;
    build_table();
    sweep("nested");

    // R2: rewrite entry 1 and observe through a lookup of its key
    write_entry(1, ek[1], 8'h5A, 8'h5B);
    lookup(ek[1], code, edges, bok);
    chk(code == 8'h5A, "R2 rewritten equal code", code, 8'h5A);
    lookup(ek[1] + 1, code, edges, bok);
    chk(code == 8'h5B, "R2 rewritten greater code", code, 8'h5B);

    // set B: 8 disjoint ranges filling all 16 entries
    np = 8;
    for (int i = 0; i < 8; i++) begin pv[i] = 8 + i; pl[i] = 4; end
    build_table();
    sweep("full");

    // set C: default route with nesting
    np = 5;
    pv[0] = 0;   pl[0] = 0;
    pv[1] = 2;   pl[1] = 2;
    pv[2] = 8;   pl[2] = 4;
    pv[3] = 136; pl[3] = 8;
    pv[4] = 7;   pl[4] = 4;
    build_table();
    sweep("default");

    // set D: host routes and one wide range
    np = 4;
    pv[0] = 16;  pl[0] = 8;
    pv[1] = 17;  pl[1] = 8;
    pv[2] = 200; pl[2] = 8;
    pv[3] = 3;   pl[3] = 2;
    build_table();
    sweep("hosts");

    // R8: a second request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'd17;
    @(negedge clk);
    req_addr = 8'd200;
    @(negedge clk);
    req_valid = 1'b0;
    edges = 2;
    while (!rsp_valid && edges < 40) begin @(negedge clk); edges++; end
    chk(edges == EXP_EDGES, "R8 first lookup timing with overlap", edges, EXP_EDGES);
    chk(rsp_code == RW'(ref_lpm(17)), "R8 code of first request", int'(rsp_code), ref_lpm(17));
    seen = 0;
    repeat (12) begin @(negedge clk); if (rsp_valid) seen++; end
    chk(seen == 0, "R8 no extra strobe", seen, 0);
    chk(rsp_code == RW'(ref_lpm(17)), "R8 code held", int'(rsp_code), ref_lpm(17));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule